// File: doc/BRIEF.md
# Outward-Sweeping Turn Indicator Lamp Sequencer

This block drives a bar of lamps split into a right half and a left half. All lamp outputs are active-low. A small step counter feeds two mirrored one-hot decoders. Each decoder lights a single lamp in its half and moves it one position per clock, starting next to the centre of the bar and running out to the end. It then starts again from the centre.

Each half has its own active-low request input. A half whose request is inactive shows all ones, so its lamps are dark. Both halves share one step counter. When both requests are active (hazard signalling), the two lit lamps therefore stay mirror images of each other on every clock. When neither request is active, the counter is held at step 0. Any new request then starts at the centre lamp. An active-high asynchronous clear forces the counter back to step 0.

The interface has no data stream. The inputs are plain level controls and the output is a plain lamp vector, so the block has no valid/ready handshake and no back-pressure.

Top module: `turn_lamp_sequencer`

## Requirements
- R1: While `clr` is high, the step counter is 0. With both requests inactive, `lamp_n` is all ones.
- R2: With only `right_req_n` low, exactly one lamp in bits 7..4 is 0. It moves 4, 5, 6, 7, 4, ... with one step per rising clock edge.
- R3: With only `left_req_n` low, exactly one lamp in bits 3..0 is 0. It moves 3, 2, 1, 0, 3, ... with one step per rising clock edge.
- R4: A half whose request input is high drives all four of its outputs to 1, whatever the other half is doing.
- R5: With both requests low, the right lamp at bit 4+k and the left lamp at bit 3-k are lit in the same cycle. This includes a half that joins while the other is already running: it joins at the running step.
- R6: While both requests are high, the counter holds step 0. The first cycle of a new request lights the centre lamp of that half (bit 4 for right, bit 3 for left).
- R7: After the outermost lamp of a half (step 3), the next step returns to the centre lamp (step 0).
- R8: In every cycle, each enabled half has exactly one lamp at 0.
- R9: Raising `clr` while a sweep is in progress returns the outputs to step 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock that advances the step |
| clr | input | 1 | Active-high asynchronous clear of the step counter |
| right_req_n | input | 1 | Active-low request to sweep the right half (bits 7..4) |
| left_req_n | input | 1 | Active-low request to sweep the left half (bits 3..0) |
| lamp_n | output | 8 | Active-low lamp vector; 0 lights a lamp |

## Verification
The bench builds the block with the default `LAMPS_PER_SIDE` of 4, which gives an 8-bit bar and a 2-bit step. With that setting a full sweep takes four clocks. Four complete sweeps per direction therefore cross the 3-to-0 wrap several times within a short run. The small depth also makes it cheap to join one half into the other's sweep at a non-zero step and check that the two lamps mirror each other. It also makes it cheap to raise the clear between edges in the middle of a hazard sweep.

// File: rtl/turn_lamp_pkg.sv
package turn_lamp_pkg;
  typedef enum logic {
    SWEEP_UP   = 1'b0,
    SWEEP_DOWN = 1'b1
  } sweep_dir_e;
endpackage

// File: rtl/lamp_step_counter.sv
module lamp_step_counter #(
  parameter int STEPS = 4,
  localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              run_n,
  output logic [STEP_W-1:0] step
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      step <= '0;
    end else if (!run_n) begin
      if (step == LAST) step <= '0;
      else              step <= step + 1'b1;
    end else begin
      step <= '0;
    end
  end

  AST_STEP_WRAPS: assert property (@(posedge clk) disable iff (clr)
    (!run_n && step == LAST) |=> (step == '0)); // R7

  AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (clr)
    (step <= LAST)); // R8
endmodule

// File: rtl/lamp_half_decoder.sv
module lamp_half_decoder
  import turn_lamp_pkg::*;
#(
  parameter int         STEPS = 4,
  parameter sweep_dir_e DIR   = SWEEP_UP,
  localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              en_n,
  input  logic [STEP_W-1:0] step,
  output logic [STEPS-1:0]  half_n
);
  for (genvar k = 0; k < STEPS; k++) begin : g_lamp
    localparam int POS = (DIR == SWEEP_UP) ? k : (STEPS - 1 - k);
    assign half_n[POS] = en_n | (step != STEP_W'(k));
  end

  AST_ONE_LAMP_LIT: assert property (@(posedge clk) disable iff (clr)
    !en_n |-> ($countones(~half_n) == 1)); // R8

  AST_DARK_WHEN_OFF: assert property (@(posedge clk) disable iff (clr)
    en_n |-> (&half_n)); // R4
endmodule

// File: rtl/turn_lamp_sequencer.sv
module turn_lamp_sequencer
  import turn_lamp_pkg::*;
#(
  parameter int LAMPS_PER_SIDE = 4,
  localparam int STEP_W = (LAMPS_PER_SIDE > 1) ? $clog2(LAMPS_PER_SIDE) : 1,
  localparam int BAR_W  = 2 * LAMPS_PER_SIDE
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             right_req_n,
  input  logic             left_req_n,
  output logic [BAR_W-1:0] lamp_n
);
  logic [STEP_W-1:0] step;
  logic              any_run_n;

  // counting stops only when neither half is requested
  assign any_run_n = right_req_n & left_req_n;

  lamp_step_counter #(.STEPS(LAMPS_PER_SIDE)) u_counter (
    .clk   (clk),
    .clr   (clr),
    .run_n (any_run_n),
    .step  (step)
  );

  lamp_half_decoder #(.STEPS(LAMPS_PER_SIDE), .DIR(SWEEP_UP)) u_right (
    .clk    (clk),
    .clr    (clr),
    .en_n   (right_req_n),
    .step   (step),
    .half_n (lamp_n[BAR_W-1:LAMPS_PER_SIDE])
  );

  lamp_half_decoder #(.STEPS(LAMPS_PER_SIDE), .DIR(SWEEP_DOWN)) u_left (
    .clk    (clk),
    .clr    (clr),
    .en_n   (left_req_n),
    .step   (step),
    .half_n (lamp_n[LAMPS_PER_SIDE-1:0])
  );

  for (genvar k = 0; k < LAMPS_PER_SIDE; k++) begin : g_mirror
    AST_HALVES_LOCKSTEP: assert property (@(posedge clk) disable iff (clr)
      (!right_req_n && !left_req_n) |->
        (lamp_n[LAMPS_PER_SIDE + k] == lamp_n[LAMPS_PER_SIDE - 1 - k])); // R5
  end

  AST_RIGHT_STARTS_CENTRE: assert property (@(posedge clk) disable iff (clr)
    ($past(right_req_n && left_req_n) && !right_req_n) |->
      !lamp_n[LAMPS_PER_SIDE]); // R6

  AST_LEFT_STARTS_CENTRE: assert property (@(posedge clk) disable iff (clr)
    ($past(right_req_n && left_req_n) && !left_req_n) |->
      !lamp_n[LAMPS_PER_SIDE-1]); // R6
endmodule

// File: tb/turn_lamp_sequencer_tb.sv
module turn_lamp_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int W = 2 * N;

  logic         clk = 1'b0;
  logic         clr = 1'b1;
  logic         right_req_n = 1'b1;
  logic         left_req_n = 1'b1;
  logic [W-1:0] lamp_n;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  turn_lamp_sequencer #(.LAMPS_PER_SIDE(N)) u_dut (
    .clk         (clk),
    .clr         (clr),
    .right_req_n (right_req_n),
    .left_req_n  (left_req_n),
    .lamp_n      (lamp_n)
  );

  function automatic logic [W-1:0] exp_lamps(bit r, bit l, int s);
    logic [W-1:0] v = '1;
    if (r) v[N + s] = 1'b0;
    if (l) v[N - 1 - s] = 1'b0;
    return v;
  endfunction

  task automatic check(string tag, logic [W-1:0] exp);
    checks++;
    if (lamp_n !== exp) begin
      failures++;
      $display("FAIL %s lamp_n actual=%b expected=%b at %0t", tag, lamp_n, exp, $time);
    end
  endtask

  task automatic set_req(bit r, bit l);
    @(negedge clk);
    right_req_n = !r;
    left_req_n  = !l;
    #1;
  endtask

  task automatic run_steps(bit r, bit l, int start, int n, string tag);
    for (int i = 0; i < n; i++) begin
      check(tag, exp_lamps(r, l, (start + i) % N));
      @(posedge clk);
      #1;
    end
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset dark", '1);
    @(negedge clk);
    clr = 1'b0;
    #1;
    check("R1 after clear release", '1);
  endtask

  task automatic t_right_only;
    set_req(1, 0);
    run_steps(1, 0, 0, 4 * N, "R2 R7 R8 R4 right sweep");
  endtask

  task automatic t_release_and_hold;
    set_req(0, 0);
    check("R4 right dropped", '1);
    repeat (3) begin
      @(posedge clk);
      #1;
      check("R4 idle dark", '1);
    end
  endtask

  task automatic t_left_only;
    set_req(0, 1);
    check("R6 left starts centre", exp_lamps(0, 1, 0));
    run_steps(0, 1, 0, 4 * N, "R3 R7 R8 R4 left sweep");
    set_req(0, 0);
    check("R4 left dropped", '1);
    @(posedge clk);
    #1;
  endtask

  task automatic t_hazard;
    set_req(1, 1);
    run_steps(1, 1, 0, 4 * N, "R5 both lockstep");
    set_req(0, 0);
    @(posedge clk);
    #1;
    check("R4 both dropped", '1);
  endtask

  task automatic t_join;
    set_req(1, 0);
    check("R6 right starts centre", exp_lamps(1, 0, 0));
    run_steps(1, 0, 0, 2, "R2 right before join");
    set_req(1, 1);
    run_steps(1, 1, 2, 4, "R5 left joins at running step");
  endtask

  task automatic t_async_clear;
    #2;
    clr = 1'b1;
    #1;
    check("R9 async clear to step 0", exp_lamps(1, 1, 0));
    @(negedge clk);
    clr = 1'b0;
    #1;
    run_steps(1, 1, 0, 4, "R9 resume after clear");
    set_req(0, 0);
    check("R4 final dark", '1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_right_only();
    t_release_and_hold();
    t_left_only();
    t_hazard();
    t_join();
    t_async_clear();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule